// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width product. An AND array builds one partial-product row per multiplier bit. Layers of 3:2 carry-save compressors then reduce those rows until only a sum vector and a carry vector remain. A single ripple carry-propagate adder combines the two vectors into the product.

The operand width is a parameter and defaults to 8 bits, which gives a 16-bit product. Carry-save reduction works on every column of equal weight in the same layer, so no pair of rows is ever added with full carry propagation. Only the last two vectors see a carry chain. A parameter places an output register after the adder. The register has an active-low asynchronous reset. With the register disabled, the block is purely combinational.

Top module: `wallace_mul`

## Requirements
- R1: `prod_o` equals the unsigned product of `a_i` and `b_i`, 2*W bits wide, for every operand pair.
- R2: When either operand is zero, the product is zero, whatever the value of the other operand.
- R3: For the largest operands (all ones, 0xFF times 0xFF at W=8) the product is 0xFE01. No compressor and no final-adder stage produces a carry out of bit 2*W-1.
- R4: Each carry-save layer keeps the arithmetic sum of its vectors equal to the sum of the partial-product rows. Reduction stops when exactly two vectors remain.
- R5: Row i of the AND array is the multiplicand shifted left by i when multiplier bit i is 1, and zero otherwise. A multiplier of 2^k therefore yields the multiplicand shifted left by k.
- R6: With `REG_OUT`=0 the product follows the operands in the same cycle, with no clock edge involved.
- R7: With `REG_OUT`=1 the product of the operands present before a rising edge of `clk` appears on `prod_o` after that edge and holds until the next edge.
- R8: With `REG_OUT`=1, a low `rst_n` clears `prod_o` to zero at once, without waiting for a clock edge. The first product appears after the first rising edge that follows release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | W | Multiplicand, unsigned |
| b_i | input | W | Multiplier, unsigned |
| prod_o | output | 2*W | Unsigned product |

## Verification
In the registered variant, a new operand pair arrives at the inputs in the same cycle that the register presents the product of the previous pair. The bench sweeps every operand pair back to back, one pair per cycle, so this overlap occurs on every cycle. A combinational copy of the block is driven with the same operands. In each cycle the combinational output is judged against the current pair and the registered output against the pair before it. A reset applied in mid-stream checks that the clear takes priority over the pending product.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // Number of vectors left after one 3:2 layer acts on n vectors
    function automatic int next_rows(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    // Vector count at the input of layer l, starting from n0 rows
    function automatic int rows_at(input int n0, input int l);
        int n;
        n = n0;
        for (int k = 0; k < l; k++) n = next_rows(n);
        return n;
    endfunction

    // Layers needed to bring n0 rows down to two vectors
    function automatic int layer_count(input int n0);
        int n;
        int c;
        n = n0;
        c = 0;
        while (n > 2) begin
            n = next_rows(n);
            c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/wt_pp_gen.sv
module wt_pp_gen #(
    parameter int W  = 8,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]          a_i,
    input  logic [W-1:0]          b_i,
    output logic [W-1:0][PW-1:0]  rows_o
);

    for (genvar r = 0; r < W; r++) begin : g_row
        logic [PW-1:0] ext_a;
        assign ext_a     = {{W{1'b0}}, a_i};
        assign rows_o[r] = (ext_a & {PW{b_i[r]}}) << r;
    end

    // Sum of all rows must match the arithmetic product
    always_comb begin
        logic [PW+7:0] acc;
        acc = '0;
        for (int r = 0; r < W; r++) acc = acc + (PW+8)'(rows_o[r]);
        if (!$isunknown({a_i, b_i}))
            AST_ROWS_PRODUCT: assert (acc == (PW+8)'({{W{1'b0}}, a_i} * {{W{1'b0}}, b_i})); // R5
    end

endmodule

// File: rtl/wt_csa_row.sv
module wt_csa_row #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x_i,
    input  logic [PW-1:0] y_i,
    input  logic [PW-1:0] z_i,
    output logic [PW-1:0] sum_o,
    output logic [PW-1:0] cry_o
);

    logic [PW-1:0] maj;

    for (genvar i = 0; i < PW; i++) begin : g_fa
        assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
        assign maj[i]   = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
    end

    assign cry_o = {maj[PW-2:0], 1'b0};

    // The carry leaving the top column is discarded; it must never be set
    always_comb begin
        if (!$isunknown(maj[PW-1]))
            AST_TOP_CARRY_ZERO: assert (maj[PW-1] == 1'b0); // R3
    end

endmodule

// File: rtl/wt_reduce.sv
module wt_reduce
    import wt_pkg::*;
#(
    parameter int W  = 8,
    localparam int PW = 2 * W,
    localparam int NL = layer_count(W)
) (
    input  logic [W-1:0][PW-1:0] rows_i,
    output logic [PW-1:0]        sum_o,
    output logic [PW-1:0]        cry_o
);

    logic [W-1:0][PW-1:0] lvl [NL+1];

    assign lvl[0] = rows_i;

    for (genvar l = 0; l < NL; l++) begin : g_layer
        localparam int N  = rows_at(W, l);
        localparam int T  = N / 3;
        localparam int R  = N % 3;
        localparam int NN = 2 * T + R;

        for (genvar t = 0; t < T; t++) begin : g_csa
            wt_csa_row #(.PW(PW)) u_csa (
                .x_i   (lvl[l][3*t]),
                .y_i   (lvl[l][3*t+1]),
                .z_i   (lvl[l][3*t+2]),
                .sum_o (lvl[l+1][2*t]),
                .cry_o (lvl[l+1][2*t+1])
            );
        end
        for (genvar r = 0; r < R; r++) begin : g_pass
            assign lvl[l+1][2*T+r] = lvl[l][3*T+r];
        end
        for (genvar j = NN; j < W; j++) begin : g_idle
            assign lvl[l+1][j] = '0;
        end
    end

    assign sum_o = lvl[NL][0];
    assign cry_o = lvl[NL][1];

    initial begin
        AST_TWO_LEFT: assert (W >= 2 && rows_at(W, NL) == 2); // R4
    end

    // Every layer carries the same arithmetic total as the input rows
    always_comb begin
        logic [PW+7:0] ref_sum;
        logic [PW+7:0] lay_sum;
        ref_sum = '0;
        for (int r = 0; r < W; r++) ref_sum = ref_sum + (PW+8)'(lvl[0][r]);
        for (int l = 1; l <= NL; l++) begin
            lay_sum = '0;
            for (int r = 0; r < W; r++) lay_sum = lay_sum + (PW+8)'(lvl[l][r]);
            if (!$isunknown(rows_i))
                AST_LAYER_SUM: assert (lay_sum == ref_sum); // R4
        end
    end

endmodule

// File: rtl/wt_cpa.sv
module wt_cpa #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x_i,
    input  logic [PW-1:0] y_i,
    output logic [PW-1:0] sum_o
);

    logic [PW:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
        assign cy[i+1]  = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
    end

    always_comb begin
        if (!$isunknown({x_i, y_i}))
            AST_NO_OVERFLOW: assert (cy[PW] == 1'b0); // R3
    end

endmodule

// File: rtl/wallace_mul.sv
module wallace_mul #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int PW     = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [PW-1:0] prod_o
);

    typedef struct packed {
        logic [PW-1:0] prod;
        logic          primed;
    } out_state_t;

    logic [W-1:0][PW-1:0] rows;
    logic [PW-1:0]        tree_sum;
    logic [PW-1:0]        tree_cry;
    logic [PW-1:0]        prod_comb;
    out_state_t           state_d;
    out_state_t           state_q;

    wt_pp_gen #(.W(W)) u_pp (
        .a_i    (a_i),
        .b_i    (b_i),
        .rows_o (rows)
    );

    wt_reduce #(.W(W)) u_tree (
        .rows_i (rows),
        .sum_o  (tree_sum),
        .cry_o  (tree_cry)
    );

    wt_cpa #(.PW(PW)) u_cpa (
        .x_i   (tree_sum),
        .y_i   (tree_cry),
        .sum_o (prod_comb)
    );

    always_comb begin
        state_d        = state_q;
        state_d.prod   = prod_comb;
        state_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    if (REG_OUT) begin : g_reg
        assign prod_o = state_q.prod;

        AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.primed |-> prod_o == ({{W{1'b0}}, $past(a_i)} * {{W{1'b0}}, $past(b_i)})); // R7

        AST_RESET_CLEAR: assert property (@(posedge clk)
            $rose(rst_n) |-> prod_o == '0); // R8
    end else begin : g_comb
        assign prod_o = prod_comb;
    end

endmodule

// File: tb/wallace_mul_bench.sv
module wallace_mul_bench;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int PW    = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic [PW-1:0] prod_r;
    logic [PW-1:0] prod_c;
    int            n_chk = 0;
    int            n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    wallace_mul #(.W(W), .REG_OUT(1'b1)) u_wallace_mul (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(prod_r));

    wallace_mul #(.W(W), .REG_OUT(1'b0)) u_wallace_mul_comb (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(prod_c));

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < W; i++) if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
        return acc;
    endfunction

    // Drive one pair at a falling edge, check the combinational copy
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        @(negedge clk);
        a = x;
        b = y;
        #1;
        chk({tag, " comb"}, prod_c, mul(x, y));
    endtask

    task automatic t_reset();
        a = 8'hC3;
        b = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R8 held in reset", prod_r, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 first product after release", prod_r, mul(8'hC3, 8'h5A));
    endtask

    task automatic t_sweep();
        logic [PW-1:0] prev;
        bit have;
        have = 1'b0;
        prev = '0;
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                @(negedge clk);
                if (have) chk("R7 registered previous pair", prod_r, prev);
                a = W'(ia);
                b = W'(ib);
                #1;
                chk("R1 R4 R6 comb current pair", prod_c, PW'(ia * ib));
                prev = PW'(ia * ib);
                have = 1'b1;
            end
        end
        @(negedge clk);
        chk("R7 registered last pair", prod_r, prev);
    endtask

    task automatic t_corners();
        apply(8'h00, 8'hA7, "R2 zero multiplicand");
        chk("R2 zero multiplicand value", prod_c, '0);
        apply(8'hE9, 8'h00, "R2 zero multiplier");
        @(negedge clk);
        chk("R2 zero registered", prod_r, '0);
        apply(8'hFF, 8'hFF, "R3 max");
        chk("R3 max value", prod_c, 16'hFE01);
        @(negedge clk);
        chk("R3 max registered", prod_r, 16'hFE01);
        for (int k = 0; k < W; k++) begin
            apply(8'hB7, W'(1) << k, "R5 power of two");
            chk("R5 shifted multiplicand", prod_c, 16'h00B7 << k);
        end
    endtask

    task automatic t_mid_reset();
        apply(8'h9D, 8'h6E, "R8 pre-reset");
        @(negedge clk);
        chk("R7 before mid reset", prod_r, mul(8'h9D, 8'h6E));
        #2;
        rst_n = 1'b0;
        #1;
        chk("R8 async clear", prod_r, '0);
        @(negedge clk);
        chk("R8 clear held", prod_r, '0);
        rst_n = 1'b1;
        apply(8'h11, 8'h22, "R8 after release");
        @(negedge clk);
        chk("R8 product after release", prod_r, 16'h0242);
    endtask

    initial begin
        t_reset();
        t_corners();
        t_mid_reset();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule